// File: doc/BRIEF.md
# UART Transmitter with Read-Back Collision Detection

This block is the transmit engine of a UART that shares a single wire, or a wired-AND line, with other senders. It sends a frame made of a low start bit, a selectable number of data bits taken least significant bit first, and a high stop bit. While a frame is on the line it compares the level it drives against the level it reads back on the receive input. A difference means another sender is pulling the line, and the block then raises a sticky collision flag that serves as an interrupt request.

Bit timing comes from an external one-cycle bit-rate enable, `bit_en`. The read-back comparison happens either on that enable or on a separate strobe, `smp_stb`, which stands in for the underflow of a one-shot timer that the start of transmission retriggers. A frame can start at a bit boundary, or it can wait for an active edge on the receive line. The block can also drop its own transmit enable when it sees a collision, and it abandons the frame at the next bit boundary whenever the transmit enable is low.

The transmit-enable condition is `te_o && tx_go`. Software sets and clears `te_o` with the one-cycle pulses `te_set` and `te_clr`, and clears the flag with the write-one pulse `irq_clr`. The effective receive level is `rxd ^ rx_inv`.

Top module: `uart_cd_tx`

## Requirements
- R1: While `rst_n` is low and after it is released, `txd` is 1, `coll_irq` is 0 and `te_o` is 0.
- R2: A frame puts a 0 start bit on `txd`, then the data bits of `tx_word` starting with bit 0, then a 1 stop bit. Each bit lasts until the next `bit_en` cycle. `len_sel` picks the data length: 0 gives 7 bits, 1 gives 8, and 2 or 3 give 9. Bits above the chosen length are not sent, and `txd` is 1 whenever no frame is in progress.
- R3: With `start_sel`=0, the start bit appears on `txd` one clock after the first `bit_en` cycle in which `te_o && tx_go` holds while the block is idle.
- R4: With `start_sel`=1, `bit_en` does not start a frame. The start bit appears one clock after a cycle in which the effective receive level has fallen (previous cycle 1, this cycle 0) while `te_o && tx_go` holds and the block is idle.
- R5: In the edge start mode, an effective receive edge that occurs while `te_o && tx_go` is false is ignored. `txd` stays 1 after the condition later becomes true, until a new edge arrives.
- R6: With `rx_inv`=1, the receive input is inverted before both the start-edge detection and the collision comparison. A raw rising edge then starts a frame, and an inverted echo of `txd` causes no collision.
- R7: With `smp_sel`=0, every `bit_en` cycle during a frame compares `txd` with the effective receive level. A difference sets `coll_irq` one clock later.
- R8: With `smp_sel`=1, the comparison is made only in `smp_stb` cycles during a frame. Differences in `bit_en` cycles without `smp_stb` leave `coll_irq` at 0.
- R9: `coll_irq` stays 1 until a one-cycle `irq_clr` pulse clears it. A new collision in the same cycle as `irq_clr` keeps it set.
- R10: With `auto_clr`=1, `te_o` falls to 0 on the same clock edge at which a collision sets `coll_irq`. With `auto_clr`=0, a collision leaves `te_o` unchanged.
- R11: If `te_o` is 0 at a `bit_en` cycle during a frame, the frame ends and `txd` is 1 from the following clock. No new frame starts while `te_o` stays 0.
- R12: `te_o` becomes 1 one clock after a `te_set` pulse and 0 one clock after a `te_clr` pulse. If both pulses arrive in the same cycle, `te_clr` wins, and an automatic clear on collision wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle bit-rate enable that marks each bit boundary |
| smp_stb | input | 1 | External read-back strobe used when `smp_sel`=1 |
| tx_word | input | DATA_W | Data word, captured when the start bit begins |
| tx_go | input | 1 | Data ready; together with `te_o` it forms the transmit-enable condition |
| te_set | input | 1 | Pulse that sets the transmit enable |
| te_clr | input | 1 | Pulse that clears the transmit enable |
| irq_clr | input | 1 | Write-one pulse that clears the collision flag |
| len_sel | input | 2 | Data length select: 0 gives 7 bits, 1 gives 8, 2 or 3 give 9 |
| smp_sel | input | 1 | Comparison source: 0 uses `bit_en`, 1 uses `smp_stb` |
| auto_clr | input | 1 | Clear the transmit enable when a collision is flagged |
| start_sel | input | 1 | Start mode: 0 starts at a bit boundary, 1 starts on a receive edge |
| rx_inv | input | 1 | Invert the receive input |
| rxd | input | 1 | Read-back receive line |
| txd | output | 1 | Transmit line, registered |
| coll_irq | output | 1 | Sticky collision flag and interrupt request |
| te_o | output | 1 | Transmit enable status |

## Verification
All three outputs are registered, so each one reflects the inputs seen at a single clock edge. `txd` moves one clock after the deciding `bit_en`, receive-edge or abort cycle. `coll_irq` and `te_o` move one clock after the mismatching sample or the `te_set`, `te_clr` or `irq_clr` pulse. The reference model in the bench updates at the same rising edge as the design and is compared at the following falling edge. Each literal check is placed at the falling edge that comes exactly the required number of edges after its stimulus was driven. Collisions are produced by corrupting a looped-back echo of `txd`, and the corruption is timed so that it covers, or deliberately avoids, the comparison cycles of each sampling mode.

// File: rtl/uart_cd_pkg.sv
package uart_cd_pkg;

  // Phase of the transmit frame
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } tx_phase_t;

  // Per-cycle decisions passed from the receive monitor
  typedef struct packed {
    logic start_go;   // begin a start bit at this edge
    logic sample_now; // compare txd with read-back at this edge
    logic rxd_eff;    // polarity-corrected read-back level
  } rx_evt_t;

endpackage

// File: rtl/uart_cd_rxmon.sv
module uart_cd_rxmon
  import uart_cd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rxd,
  input  logic    rx_inv,
  input  logic    start_sel,
  input  logic    smp_sel,
  input  logic    bit_en,
  input  logic    smp_stb,
  input  logic    te,
  input  logic    tx_go,
  input  logic    busy,
  output rx_evt_t evt
);

  logic rx_eff;
  logic prev_q, prev_n;
  logic fall;
  logic cond;

  // polarity correction feeds both edge detection and comparison
  always_comb begin
    rx_eff = rxd ^ rx_inv;
    fall   = prev_q & ~rx_eff;
    cond   = te & tx_go;
    prev_n = rx_eff;
  end

  always_comb begin
    evt.rxd_eff    = rx_eff;
    evt.start_go   = ~busy & cond & (start_sel ? fall : bit_en);
    evt.sample_now = busy & (smp_sel ? smp_stb : bit_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_n;
    end
  end

endmodule

// File: rtl/uart_cd_frame.sv
module uart_cd_frame
  import uart_cd_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              start_go,
  input  logic              te,
  input  logic [1:0]        len_sel,
  input  logic [DATA_W-1:0] tx_word,
  output logic              txd,
  output logic              busy
);

  localparam int MIN_BITS = DATA_W - 2;
  localparam int IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_phase_t         ph_q, ph_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              txd_q, txd_n;
  logic [IDX_W-1:0]  last_idx;
  int unsigned       nb_c;

  // number of data bits for this frame, clipped to the word width
  always_comb begin
    nb_c = 32'(MIN_BITS) + 32'(len_sel);
    if (nb_c > 32'(DATA_W)) nb_c = 32'(DATA_W);
    last_idx = IDX_W'(nb_c - 32'd1);
  end

  always_comb begin
    ph_n  = ph_q;
    idx_n = idx_q;
    sh_n  = sh_q;
    txd_n = txd_q;
    if (ph_q == PH_IDLE) begin
      txd_n = 1'b1;
      if (start_go) begin
        ph_n  = PH_START;
        txd_n = 1'b0;
        sh_n  = tx_word;
        idx_n = '0;
      end
    end else if (bit_en) begin
      if (!te) begin
        ph_n  = PH_IDLE;
        txd_n = 1'b1;
      end else begin
        case (ph_q)
          PH_START: begin
            ph_n  = PH_DATA;
            idx_n = '0;
            txd_n = sh_q[0];
          end
          PH_DATA: begin
            if (idx_q == last_idx) begin
              ph_n  = PH_STOP;
              txd_n = 1'b1;
            end else begin
              idx_n = idx_q + 1'b1;
              sh_n  = sh_q >> 1;
              txd_n = sh_q[1];
            end
          end
          default: begin
            ph_n  = PH_IDLE;
            txd_n = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
      sh_q  <= '0;
      txd_q <= 1'b1;
    end else begin
      ph_q  <= ph_n;
      idx_q <= idx_n;
      sh_q  <= sh_n;
      txd_q <= txd_n;
    end
  end

  assign txd  = txd_q;
  assign busy = (ph_q != PH_IDLE);

endmodule

// File: rtl/uart_cd_coll.sv
module uart_cd_coll (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_now,
  input  logic txd,
  input  logic rxd_eff,
  input  logic auto_clr,
  input  logic irq_clr,
  input  logic te_set,
  input  logic te_clr,
  output logic coll_irq,
  output logic te
);

  logic mism;
  logic irq_q, irq_n;
  logic te_q, te_n;

  always_comb begin
    mism  = sample_now & (txd ^ rxd_eff);
    irq_n = irq_q;
    if (mism)         irq_n = 1'b1;
    else if (irq_clr) irq_n = 1'b0;
    te_n = te_q;
    if (mism && auto_clr) te_n = 1'b0;
    else if (te_clr)      te_n = 1'b0;
    else if (te_set)      te_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      te_q  <= 1'b0;
    end else begin
      irq_q <= irq_n;
      te_q  <= te_n;
    end
  end

  assign coll_irq = irq_q;
  assign te       = te_q;

endmodule

// File: rtl/uart_cd_tx.sv
module uart_cd_tx
  import uart_cd_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              smp_stb,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tx_go,
  input  logic              te_set,
  input  logic              te_clr,
  input  logic              irq_clr,
  input  logic [1:0]        len_sel,
  input  logic              smp_sel,
  input  logic              auto_clr,
  input  logic              start_sel,
  input  logic              rx_inv,
  input  logic              rxd,
  output logic              txd,
  output logic              coll_irq,
  output logic              te_o
);

  rx_evt_t evt;
  logic    busy;
  logic    te;
  logic    txd_w;

  uart_cd_rxmon u_rxmon (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd       (rxd),
    .rx_inv    (rx_inv),
    .start_sel (start_sel),
    .smp_sel   (smp_sel),
    .bit_en    (bit_en),
    .smp_stb   (smp_stb),
    .te        (te),
    .tx_go     (tx_go),
    .busy      (busy),
    .evt       (evt)
  );

  uart_cd_frame #(.DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .start_go (evt.start_go),
    .te       (te),
    .len_sel  (len_sel),
    .tx_word  (tx_word),
    .txd      (txd_w),
    .busy     (busy)
  );

  uart_cd_coll u_coll (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_now (evt.sample_now),
    .txd        (txd_w),
    .rxd_eff    (evt.rxd_eff),
    .auto_clr   (auto_clr),
    .irq_clr    (irq_clr),
    .te_set     (te_set),
    .te_clr     (te_clr),
    .coll_irq   (coll_irq),
    .te         (te)
  );

  assign txd  = txd_w;
  assign te_o = te;

endmodule

// File: rtl/uart_cd_tx_chk.sv
module uart_cd_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic tx_go,
  input logic irq_clr,
  input logic auto_clr,
  input logic txd,
  input logic coll_irq,
  input logic te_o,
  input logic busy
);

  // R2: the line is marking whenever no frame is running
  a_r2_idle_marking: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R2: the first cycle of a frame drives the low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  // R3: a frame only starts when the enable condition held
  a_r3_start_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(te_o && tx_go));

  // R9: the flag holds without a clear pulse
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_irq && !irq_clr) |=> coll_irq);

  // R10: automatic clear drops the enable together with the flag
  a_r10_autoclr: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(coll_irq) && $past(auto_clr)) |-> !te_o);

  // R11: a bit boundary with the enable low ends the frame
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_en && !te_o) |=> (!busy && txd));

endmodule

bind uart_cd_tx uart_cd_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_en   (bit_en),
  .tx_go    (tx_go),
  .irq_clr  (irq_clr),
  .auto_clr (auto_clr),
  .txd      (txd),
  .coll_irq (coll_irq),
  .te_o     (te_o),
  .busy     (busy)
);

// File: tb/uart_cd_tx_tb_top.sv
`timescale 1ns/1ps
module uart_cd_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en, smp_stb, tx_go, te_set, te_clr, irq_clr;
  logic [8:0] tx_word;
  logic [1:0] len_sel;
  logic       smp_sel, auto_clr, start_sel, rx_inv;
  logic       rxd, txd, coll_irq, te_o;
  logic       loop, corrupt, rxd_force;
  int         checks = 0, errors = 0, cyc_cnt = 0, bcnt = 0;
  string      req = "R1";
  bit         done = 0;

  always #2 clk = ~clk;

  assign rxd = loop ? (txd ^ rx_inv ^ corrupt) : rxd_force;

  uart_cd_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .smp_stb(smp_stb),
    .tx_word(tx_word), .tx_go(tx_go), .te_set(te_set), .te_clr(te_clr),
    .irq_clr(irq_clr), .len_sel(len_sel), .smp_sel(smp_sel),
    .auto_clr(auto_clr), .start_sel(start_sel), .rx_inv(rx_inv),
    .rxd(rxd), .txd(txd), .coll_irq(coll_irq), .te_o(te_o)
  );

  // bit-rate enable: one cycle in four
  always @(negedge clk) begin
    bit_en = (bcnt == 3);
    bcnt   = (bcnt == 3) ? 0 : bcnt + 1;
  end

  // behavioural reference model
  int         m_ph, m_idx;
  logic [8:0] m_word;
  logic       m_txd, m_irq, m_te, m_prev;
  always @(posedge clk or negedge rst_n) begin
    logic rxe, cond, edg, samp, mism;
    int   nbits;
    if (!rst_n) begin
      m_ph = 0; m_idx = 0; m_word = '0;
      m_txd = 1; m_irq = 0; m_te = 0; m_prev = 1;
    end else begin
      rxe   = rxd ^ rx_inv;
      cond  = m_te && tx_go;
      edg   = m_prev && !rxe;
      nbits = (len_sel == 0) ? 7 : (len_sel == 1) ? 8 : 9;
      samp  = (m_ph != 0) && (smp_sel ? smp_stb : bit_en);
      mism  = samp && (m_txd != rxe);
      if (m_ph == 0) begin
        if (cond && (start_sel ? edg : bit_en)) begin
          m_ph = 1; m_txd = 0; m_word = tx_word;
        end
      end else if (bit_en) begin
        if (!m_te) begin
          m_ph = 0; m_txd = 1;
        end else if (m_ph == 1) begin
          m_ph = 2; m_idx = 0; m_txd = m_word[0];
        end else if (m_ph == 2) begin
          if (m_idx == nbits - 1) begin
            m_ph = 3; m_txd = 1;
          end else begin
            m_idx++; m_txd = m_word[m_idx];
          end
        end else begin
          m_ph = 0; m_txd = 1;
        end
      end
      if (mism) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (mism && auto_clr) m_te = 0;
      else if (te_clr) m_te = 0;
      else if (te_set) m_te = 1;
      m_prev = rxe;
    end
  end

  task automatic chk(string r, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", r, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk(req, "txd", txd, m_txd);
      chk(req, "coll_irq", coll_irq, m_irq);
      chk(req, "te_o", te_o, m_te);
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_te_set();
    te_set = 1; cyc(1); te_set = 0;
  endtask

  task automatic pulse_te_clr();
    te_clr = 1; cyc(1); te_clr = 0;
  endtask

  task automatic pulse_irq_clr();
    irq_clr = 1; cyc(1); irq_clr = 0;
  endtask

  task automatic wait_busy();
    for (int n = 0; n < 200 && m_ph == 0; n++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 400 && m_ph != 0; n++) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; smp_stb = 0; tx_go = 0; te_set = 0; te_clr = 0; irq_clr = 0;
    tx_word = 9'h0A5; len_sel = 2'd1; smp_sel = 0; auto_clr = 0;
    start_sel = 0; rx_inv = 0; loop = 1; corrupt = 0; rxd_force = 1;
    cyc(4);
    chk("R1", "txd in reset", txd, 1'b1);
    chk("R1", "irq in reset", coll_irq, 1'b0);
    chk("R1", "te in reset", te_o, 1'b0);
    rst_n = 1;
    cyc(2);
    chk("R1", "te after reset", te_o, 1'b0);

    // R12 set/clear priority
    req = "R12";
    te_set = 1; te_clr = 1; cyc(1); te_set = 0; te_clr = 0;
    chk("R12", "te set+clr", te_o, 1'b0);
    pulse_te_set();
    chk("R12", "te after set", te_o, 1'b1);

    // R3 bit-boundary start, R2 frame lengths
    req = "R3";
    tx_go = 1;
    wait_busy();
    chk("R2", "start bit low", txd, 1'b0);
    req = "R2";
    cyc(48); tx_go = 0; wait_idle();
    len_sel = 2'd0; tx_word = 9'h1B3; tx_go = 1; cyc(40); tx_go = 0; wait_idle();
    len_sel = 2'd2; tx_word = 9'h15A; tx_go = 1; cyc(48); tx_go = 0; wait_idle();
    len_sel = 2'd3; tx_word = 9'h133; tx_go = 1; cyc(48); tx_go = 0; wait_idle();
    len_sel = 2'd1; tx_word = 9'h0A5;
    cyc(6);

    // R4 receive-edge start
    req = "R4";
    start_sel = 1; loop = 0; rxd_force = 1; tx_go = 1;
    cyc(12);
    chk("R4", "no start without edge", txd, 1'b1);
    rxd_force = 0; cyc(1);
    chk("R4", "start after edge", txd, 1'b0);
    loop = 1;
    wait_idle(); tx_go = 0; cyc(4);

    // R5 early edge ignored
    req = "R5";
    pulse_te_clr();
    loop = 0; rxd_force = 1; cyc(2);
    rxd_force = 0; cyc(2);
    pulse_te_set(); tx_go = 1;
    cyc(16);
    chk("R5", "early edge ignored", txd, 1'b1);
    rxd_force = 1; cyc(2);
    rxd_force = 0; cyc(1);
    chk("R5", "later edge starts", txd, 1'b0);
    loop = 1;
    wait_idle(); tx_go = 0; cyc(4);

    // R6 inverted receive polarity
    req = "R6";
    rx_inv = 1; loop = 0; rxd_force = 0; cyc(3);
    tx_go = 1; rxd_force = 1; cyc(1);
    chk("R6", "raw rising edge starts", txd, 1'b0);
    loop = 1;
    wait_idle(); tx_go = 0;
    chk("R6", "inverted echo no collision", coll_irq, 1'b0);
    rx_inv = 0; start_sel = 0; cyc(4);

    // R7 comparison on bit boundaries, no auto clear
    req = "R7";
    tx_go = 1; wait_busy(); cyc(6);
    corrupt = 1; cyc(5); corrupt = 0; cyc(2);
    chk("R7", "collision flagged", coll_irq, 1'b1);
    chk("R10", "te kept without auto clear", te_o, 1'b1);
    tx_go = 0; wait_idle();

    // R9 sticky flag and clear
    req = "R9";
    cyc(10);
    chk("R9", "flag sticky", coll_irq, 1'b1);
    pulse_irq_clr();
    chk("R9", "flag cleared", coll_irq, 1'b0);

    // R8 strobe-based comparison
    req = "R8";
    smp_sel = 1; tx_go = 1; wait_busy(); cyc(6);
    corrupt = 1; cyc(5); corrupt = 0; cyc(2);
    chk("R8", "bit_en mismatch ignored", coll_irq, 1'b0);
    corrupt = 1; smp_stb = 1; cyc(1); corrupt = 0; smp_stb = 0; cyc(1);
    chk("R8", "strobe mismatch flagged", coll_irq, 1'b1);
    tx_go = 0; wait_idle();
    // R9 set wins over clear
    req = "R9";
    pulse_irq_clr();
    tx_go = 1; wait_busy(); cyc(6);
    corrupt = 1; smp_stb = 1; irq_clr = 1; cyc(1);
    corrupt = 0; smp_stb = 0; irq_clr = 0;
    chk("R9", "set wins over clear", coll_irq, 1'b1);
    tx_go = 0; wait_idle(); pulse_irq_clr();
    smp_sel = 0;

    // R10 auto clear, R11 abort
    req = "R10";
    auto_clr = 1; tx_go = 1; wait_busy(); cyc(6);
    corrupt = 1; cyc(5); corrupt = 0;
    chk("R10", "flag set", coll_irq, 1'b1);
    chk("R10", "te auto cleared", te_o, 1'b0);
    req = "R11";
    cyc(5);
    chk("R11", "aborted line idle", txd, 1'b1);
    auto_clr = 0; pulse_irq_clr(); pulse_te_set();

    // R11 software clear mid-frame
    wait_busy(); cyc(9);
    pulse_te_clr();
    cyc(5);
    chk("R11", "abort after te_clr", txd, 1'b1);
    cyc(10);
    chk("R11", "no restart with te low", txd, 1'b1);
    tx_go = 0; cyc(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule